// File: doc/BRIEF.md
# Descriptor Chain Walker with Cycle-Bit Ownership

This block is the per-channel sequencer in front of a data mover. It reads transfer descriptors one at a time from a contiguous descriptor area through a simple word-wide read port. For each valid descriptor it hands the source address, destination address and byte count to the mover, and it waits for the mover's completion before it moves on to the next descriptor. A link element sends the walk back to an arbitrary pointer, usually the start of the area. It also inverts the cycle state the walker expects, so software can refill the same memory for the next pass and the walker can tell fresh entries from stale ones.

A descriptor whose change bit differs from the expected cycle state is not owned by the walker yet. The walker then parks in IDLE with its pointer unchanged, and a later doorbell makes it fetch that same slot again. Completing an element that has its local or remote interrupt flag set produces a one-cycle done pulse on the matching output. A zero-length element or a read error ends the walk with a one-cycle abort pulse.

The states are IDLE, FETCH, CHECK, ISSUE, WAIT_DONE, ADVANCE and LINK. The transitions are:
- IDLE to FETCH on a doorbell.
- FETCH to CHECK when all words are in, or FETCH to IDLE on a read error.
- CHECK to IDLE on a change-bit mismatch or a zero length, CHECK to LINK for a link element, and CHECK to ISSUE otherwise.
- ISSUE to WAIT_DONE always.
- WAIT_DONE to ADVANCE when the mover reports done.
- ADVANCE to FETCH and LINK to FETCH always.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the walker is idle (`busy`=0), requests neither a read nor a transfer, and reports `cycle_state`=0.
- R2: A descriptor is six 32-bit words at consecutive byte addresses ptr+0, +4, ... +20, read in that order with one read outstanding at a time: word0 control (bit0 change bit, bit1 link, bit2 local interrupt enable, bit3 remote interrupt enable), word1 length, words 2/3 source low/high, words 4/5 destination low/high. A link element carries its 64-bit next pointer in words 2/3. The two low bits of any loaded pointer are forced to zero.
- R3: A valid element produces exactly one one-cycle `xfer_req` carrying its source, destination and length. The walker fetches nothing more until `xfer_done`, and the next descriptor is then read at ptr+24.
- R4: An element whose change bit differs from the cycle state produces no transfer and no interrupt. The walker returns to IDLE with its pointer kept, and a later doorbell alone re-reads that slot.
- R5: A link element whose change bit matches makes the walker jump to its pointer and invert `cycle_state` in the same step, with no transfer.
- R6: When an element completes, `irq_done_local` and `irq_done_remote` each pulse for one cycle, in the cycle after `xfer_done`, if that element's local or remote enable bit is set.
- R7: A matching non-link element of length 0 produces no transfer, one `irq_abort` pulse, and a return to IDLE.
- R8: A read returned with `rd_err` produces one `irq_abort` pulse and a return to IDLE, with no transfer.
- R9: `chan_init` and `doorbell` have no effect while `busy` is 1.
- R10: When `chan_init` and `doorbell` are sampled in the same idle cycle, the walk starts at the newly loaded `init_base` with the newly loaded `init_cycle`.
- R11: Source and destination addresses pass through at any byte alignment, and any 32-bit length from 1 to 0xFFFFFFFF passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_init | input | 1 | Load pointer and cycle state (idle only) |
| init_base | input | 64 | Descriptor pointer loaded by chan_init |
| init_cycle | input | 1 | Cycle state loaded by chan_init |
| doorbell | input | 1 | Start or resume the walk (idle only) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| rd_err | input | 1 | Read response carries an error |
| xfer_req | output | 1 | One-cycle transfer request to the mover |
| xfer_src | output | 64 | Transfer source address |
| xfer_dst | output | 64 | Transfer destination address |
| xfer_len | output | 32 | Transfer length in bytes |
| xfer_done | input | 1 | Mover completion pulse |
| irq_done_local | output | 1 | Done pulse for the local enable |
| irq_done_remote | output | 1 | Done pulse for the remote enable |
| irq_abort | output | 1 | Abort pulse |
| busy | output | 1 | Walker is not in IDLE |
| cycle_state | output | 1 | Change-bit value currently expected |

## Verification
Two things can meet in one cycle: a pointer load and a doorbell. Every fresh walk in the bench raises `chan_init` and `doorbell` together, so the first read address and the transfers that follow show whether the new pointer and cycle state were taken before the first fetch. Doorbell and pointer loads are also pulsed together in the middle of a long walk. The resulting transfer stream, the final `cycle_state` and a later resume-only doorbell that continues from the old slot show that the mid-walk pulses were discarded.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT_DONE,
        ST_ADVANCE,
        ST_LINK
    } walk_state_e;

    // control word bit positions (decoded by software-built descriptors)
    localparam int CTRL_CB   = 0;
    localparam int CTRL_LINK = 1;
    localparam int CTRL_LIE  = 2;
    localparam int CTRL_RIE  = 3;

    localparam int W_CTRL = 0;
    localparam int W_LEN  = 1;
    localparam int W_SRC  = 2;
endpackage

// File: rtl/dcw_fetch.sv
module dcw_fetch #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    parameter int NWORDS = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            go,
    input  logic [ADDR_W-1:0]               base,
    output logic                            rd_req,
    output logic [ADDR_W-1:0]               rd_addr,
    input  logic                            rd_valid,
    input  logic [DATA_W-1:0]               rd_data,
    input  logic                            rd_err,
    output logic [NWORDS-1:0][DATA_W-1:0]   words,
    output logic                            fin,
    output logic                            err
);
    localparam int IDX_W = $clog2(NWORDS);
    localparam int BYTES = DATA_W / 8;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

    logic [IDX_W-1:0] idx;
    logic             waiting;

    assign rd_req  = go && !waiting && !fin;
    assign rd_addr = base + ADDR_W'(idx) * ADDR_W'(BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            waiting <= 1'b0;
            fin     <= 1'b0;
            err     <= 1'b0;
        end else if (!go) begin
            idx     <= '0;
            waiting <= 1'b0;
            fin     <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (rd_req) begin
                waiting <= 1'b1;
            end
            if (waiting && rd_valid) begin
                waiting <= 1'b0;
                if (rd_err) begin
                    err <= 1'b1;
                    fin <= 1'b1;
                end else if (idx == LAST) begin
                    fin <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (go && waiting && rd_valid && !rd_err && idx == IDX_W'(g)) begin
                words[g] <= rd_data;
            end
        end
    end
endmodule

// File: rtl/dcw_ptr.sv
module dcw_ptr #(
    parameter int ADDR_W     = 64,
    parameter int DESC_BYTES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_en,
    input  logic [ADDR_W-1:0] init_base,
    input  logic              init_cyc,
    input  logic              adv_en,
    input  logic              link_en,
    input  logic [ADDR_W-1:0] link_ptr,
    output logic [ADDR_W-1:0] ptr,
    output logic              cyc
);
    function automatic logic [ADDR_W-1:0] align4(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            cyc <= 1'b0;
        end else if (init_en) begin
            ptr <= align4(init_base);
            cyc <= init_cyc;
        end else if (link_en) begin
            ptr <= align4(link_ptr);
            cyc <= ~cyc;
        end else if (adv_en) begin
            ptr <= ptr + ADDR_W'(DESC_BYTES);
        end
    end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
    import dcw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_init,
    input  logic [ADDR_W-1:0] init_base,
    input  logic              init_cycle,
    input  logic              doorbell,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [DATA_W-1:0] xfer_len,
    input  logic              xfer_done,
    output logic              irq_done_local,
    output logic              irq_done_remote,
    output logic              irq_abort,
    output logic              busy,
    output logic              cycle_state
);
    localparam int AW_WORDS   = ADDR_W / DATA_W;
    localparam int W_DST      = W_SRC + AW_WORDS;
    localparam int NWORDS     = 2 + 2 * AW_WORDS;
    localparam int DESC_BYTES = NWORDS * (DATA_W / 8);

    walk_state_e state, state_nx;

    logic [NWORDS-1:0][DATA_W-1:0] fw;
    logic              f_fin, f_err, f_go;
    logic [ADDR_W-1:0] ptr;
    logic              cyc;
    logic [ADDR_W-1:0] d_src, d_dst;
    logic [DATA_W-1:0] d_len;
    logic              d_cb, d_link, d_lie, d_rie;
    logic              cb_ok, len_zero;
    logic              init_en, adv_en, link_en;

    always_comb begin
        for (int k = 0; k < AW_WORDS; k++) begin
            d_src[k*DATA_W +: DATA_W] = fw[W_SRC + k];
            d_dst[k*DATA_W +: DATA_W] = fw[W_DST + k];
        end
    end

    assign d_len    = fw[W_LEN];
    assign d_cb     = fw[W_CTRL][CTRL_CB];
    assign d_link   = fw[W_CTRL][CTRL_LINK];
    assign d_lie    = fw[W_CTRL][CTRL_LIE];
    assign d_rie    = fw[W_CTRL][CTRL_RIE];
    assign cb_ok    = (d_cb == cyc);
    assign len_zero = (d_len == '0);

    dcw_fetch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NWORDS (NWORDS)
    ) fetch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (f_go),
        .base     (ptr),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .words    (fw),
        .fin      (f_fin),
        .err      (f_err)
    );

    dcw_ptr #(
        .ADDR_W     (ADDR_W),
        .DESC_BYTES (DESC_BYTES)
    ) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_en   (init_en),
        .init_base (init_base),
        .init_cyc  (init_cycle),
        .adv_en    (adv_en),
        .link_en   (link_en),
        .link_ptr  (d_src),
        .ptr       (ptr),
        .cyc       (cyc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (doorbell) state_nx = ST_FETCH;
            ST_FETCH:     if (f_fin) state_nx = f_err ? ST_IDLE : ST_CHECK;
            ST_CHECK: begin
                if (!cb_ok)       state_nx = ST_IDLE;
                else if (d_link)  state_nx = ST_LINK;
                else if (len_zero) state_nx = ST_IDLE;
                else              state_nx = ST_ISSUE;
            end
            ST_ISSUE:     state_nx = ST_WAIT_DONE;
            ST_WAIT_DONE: if (xfer_done) state_nx = ST_ADVANCE;
            ST_ADVANCE:   state_nx = ST_FETCH;
            ST_LINK:      state_nx = ST_FETCH;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        f_go            = (state == ST_FETCH);
        busy            = (state != ST_IDLE);
        init_en         = (state == ST_IDLE) && chan_init;
        adv_en          = (state == ST_ADVANCE);
        link_en         = (state == ST_LINK);
        xfer_req        = (state == ST_ISSUE);
        irq_done_local  = (state == ST_ADVANCE) && d_lie;
        irq_done_remote = (state == ST_ADVANCE) && d_rie;
        irq_abort       = ((state == ST_FETCH) && f_fin && f_err) ||
                          ((state == ST_CHECK) && cb_ok && !d_link && len_zero);
        xfer_src        = d_src;
        xfer_dst        = d_dst;
        xfer_len        = d_len;
        cycle_state     = cyc;
    end
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_req,
    input logic [1:0] rd_lsb,
    input logic       xfer_req,
    input logic       xfer_done,
    input logic       irq_done_local,
    input logic       irq_done_remote,
    input logic       irq_abort,
    input logic       busy
);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !xfer_req));

    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_lsb == 2'b00));

    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);

    assert_local_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_local |-> $past(xfer_done));

    assert_remote_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_remote |-> $past(xfer_done));

    assert_abort_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_abort |-> (!xfer_req && !irq_done_local && !irq_done_remote));

    assert_abort_ends_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_abort |=> !busy);
endmodule

bind desc_chain_walker dcw_checker chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_req          (rd_req),
    .rd_lsb          (rd_addr[1:0]),
    .xfer_req        (xfer_req),
    .xfer_done       (xfer_done),
    .irq_done_local  (irq_done_local),
    .irq_done_remote (irq_done_remote),
    .irq_abort       (irq_abort),
    .busy            (busy)
);

// File: tb/desc_chain_walker_tb_top.sv
module desc_chain_walker_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] src;
        logic [63:0] dst;
        logic [31:0] len;
        bit          lie;
        bit          rie;
    } xf_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_init = 1'b0;
    logic [63:0] init_base = '0;
    logic        init_cycle = 1'b0;
    logic        doorbell = 1'b0;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        rd_err = 1'b0;
    logic        xfer_req;
    logic [63:0] xfer_src, xfer_dst;
    logic [31:0] xfer_len;
    logic        xfer_done = 1'b0;
    logic        irq_done_local, irq_done_remote, irq_abort, busy, cycle_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [256];
    xf_t         exp_q[$];
    xf_t         last_xf;
    logic [63:0] m_ptr = '0;
    bit          m_cyc = 1'b0;
    int exp_li, exp_ri, exp_ab, got_li, got_ri, got_ab;
    int mv_cnt = 0;
    int mv_seed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_chain_walker dut_i (
        .clk(clk), .rst_n(rst_n), .chan_init(chan_init), .init_base(init_base),
        .init_cycle(init_cycle), .doorbell(doorbell), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .xfer_req(xfer_req),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len), .xfer_done(xfer_done),
        .irq_done_local(irq_done_local), .irq_done_remote(irq_done_remote),
        .irq_abort(irq_abort), .busy(busy), .cycle_state(cycle_state)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory: one-cycle response, error above 1 KiB
    always @(posedge clk) begin
        rd_valid <= rd_req;
        if (rd_req) begin
            if (rd_addr[63:10] != '0) begin
                rd_err  <= 1'b1;
                rd_data <= '0;
            end else begin
                rd_err  <= 1'b0;
                rd_data <= mem[rd_addr[9:2]];
            end
        end
    end

    // mover: done 1..3 cycles after the request
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (xfer_req) begin
            mv_cnt  <= 1 + (mv_seed % 3);
            mv_seed <= mv_seed + 1;
        end else if (mv_cnt != 0) begin
            mv_cnt <= mv_cnt - 1;
            if (mv_cnt == 1) xfer_done <= 1'b1;
        end
    end

    // per-clock comparison against the model's expected stream
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (xfer_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected transfer", longint'(xfer_src), 0);
                end else begin
                    last_xf = exp_q.pop_front();
                    chk(xfer_src == last_xf.src, "R3/R11 source", longint'(xfer_src), longint'(last_xf.src));
                    chk(xfer_dst == last_xf.dst, "R3/R11 destination", longint'(xfer_dst), longint'(last_xf.dst));
                    chk(xfer_len == last_xf.len, "R3/R11 length", longint'(xfer_len), longint'(last_xf.len));
                end
            end
            if (irq_done_local) begin
                got_li++;
                chk(last_xf.lie, "R6 local pulse for flagged element", 1, longint'(last_xf.lie));
            end
            if (irq_done_remote) begin
                got_ri++;
                chk(last_xf.rie, "R6 remote pulse for flagged element", 1, longint'(last_xf.rie));
            end
            if (irq_abort) got_ab++;
        end
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic put_desc(input int a, input bit cb, input bit lie, input bit rie,
                            input logic [63:0] src, input logic [63:0] dst, input logic [31:0] len);
        mem[a/4]     = {28'd0, rie, lie, 1'b0, cb};
        mem[a/4 + 1] = len;
        mem[a/4 + 2] = src[31:0];
        mem[a/4 + 3] = src[63:32];
        mem[a/4 + 4] = dst[31:0];
        mem[a/4 + 5] = dst[63:32];
    endtask

    task automatic put_link(input int a, input bit cb, input logic [63:0] nxt);
        mem[a/4]     = {30'd0, 1'b1, cb};
        mem[a/4 + 1] = 32'd0;
        mem[a/4 + 2] = nxt[31:0];
        mem[a/4 + 3] = nxt[63:32];
        mem[a/4 + 4] = 32'd0;
        mem[a/4 + 5] = 32'd0;
    endtask

    // behavioural walk of the descriptor memory
    task automatic model();
        logic [31:0] c;
        xf_t x;
        for (int i = 0; i < 64; i++) begin
            if (m_ptr + 64'd23 >= 64'd1024) begin exp_ab++; break; end
            c = mem[m_ptr[9:2]];
            if (c[0] != m_cyc) break;
            if (c[1]) begin
                m_ptr = {mem[m_ptr[9:2] + 3], mem[m_ptr[9:2] + 2]} & ~64'd3;
                m_cyc = ~m_cyc;
                continue;
            end
            if (mem[m_ptr[9:2] + 1] == 32'd0) begin exp_ab++; break; end
            x.len = mem[m_ptr[9:2] + 1];
            x.src = {mem[m_ptr[9:2] + 3], mem[m_ptr[9:2] + 2]};
            x.dst = {mem[m_ptr[9:2] + 5], mem[m_ptr[9:2] + 4]};
            x.lie = c[2];
            x.rie = c[3];
            if (x.lie) exp_li++;
            if (x.rie) exp_ri++;
            exp_q.push_back(x);
            m_ptr = m_ptr + 64'd24;
        end
    endtask

    task automatic run(input bit do_init, input logic [63:0] base, input bit cyc,
                       input bit poke, input string tag);
        int n;
        if (do_init) begin m_ptr = base & ~64'd3; m_cyc = cyc; end
        exp_q.delete();
        exp_li = 0; exp_ri = 0; exp_ab = 0;
        got_li = 0; got_ri = 0; got_ab = 0;
        model();
        @(negedge clk);
        chan_init = do_init; init_base = base; init_cycle = cyc; doorbell = 1'b1;
        @(negedge clk);
        chan_init = 1'b0; doorbell = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke && (n == 10 || n == 30)) begin
                chan_init = 1'b1; init_base = 64'h100; init_cycle = ~cyc; doorbell = 1'b1;
            end else begin
                chan_init = 1'b0; doorbell = 1'b0;
            end
        end
        chan_init = 1'b0; doorbell = 1'b0;
        @(negedge clk);
        chk(!busy, {tag, " walk ended"}, longint'(busy), 0);
        chk(exp_q.size() == 0, {tag, " all transfers seen"}, exp_q.size(), 0);
        chk(got_li == exp_li, {tag, " R6 local count"}, got_li, exp_li);
        chk(got_ri == exp_ri, {tag, " R6 remote count"}, got_ri, exp_ri);
        chk(got_ab == exp_ab, {tag, " R7/R8 abort count"}, got_ab, exp_ab);
        chk(cycle_state == m_cyc, {tag, " R5 cycle state"}, longint'(cycle_state), longint'(m_cyc));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !rd_req && !xfer_req, "R1 idle after reset", longint'(busy), 0);
        chk(cycle_state == 1'b0, "R1 cycle state after reset", longint'(cycle_state), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R6 R10 R11: odd addresses, max length, link with low bits set
        put_desc(0,  1, 0, 0, 64'h0000_0001_2345_6781, 64'h0000_00AB_CDEF_0003, 32'd17);
        put_desc(24, 1, 1, 0, 64'h8000_0000_0000_0007, 64'h0000_0000_0000_0FFD, 32'hFFFF_FFFF);
        put_desc(48, 1, 1, 1, 64'h0000_0000_1000_0002, 64'h7FFF_FFFF_FFFF_FFFF, 32'd1);
        put_link(72, 1, 64'h2);
        run(1'b1, 64'h0, 1'b1, 1'b0, "R10 init+doorbell walk");

        // R4: refill first two slots for cycle 0, third stays stale; resume with doorbell only
        put_desc(0,  0, 0, 1, 64'h0000_0000_0000_0111, 64'h0000_0000_0000_0222, 32'd64);
        put_desc(24, 0, 1, 0, 64'h0000_0000_0000_0333, 64'h0000_0000_0000_0444, 32'd8);
        run(1'b0, 64'h0, 1'b0, 1'b0, "R4 resume after stale stop");

        // R7 zero length abort
        put_desc(256, 0, 0, 0, 64'h55, 64'h66, 32'd5);
        put_desc(280, 0, 1, 1, 64'h77, 64'h88, 32'd0);
        run(1'b1, 64'h100, 1'b0, 1'b0, "R7 zero length");

        // R8 read error on the next slot
        put_desc(1000, 1, 0, 0, 64'h99, 64'hAA, 32'd3);
        run(1'b1, 64'd1000, 1'b1, 1'b0, "R8 fetch error");

        // R9 doorbell and init pulsed mid-walk are ignored
        for (int k = 0; k < 5; k++)
            put_desc(512 + 24*k, 1, (k == 4), 0, 64'h1000 + 64'(k), 64'h2000 + 64'(3*k), 32'd100 + 32'(k));
        mem[(512 + 120)/4] = 32'd0;
        run(1'b1, 64'h200, 1'b1, 1'b1, "R9 busy pokes");

        // R9 follow-up: pointer kept at 0x278, resume follows a link there
        put_link(632, 1, 64'h300);
        put_desc(768, 0, 1, 1, 64'hDEAD_0001, 64'hBEEF_0003, 32'd12);
        mem[(768 + 24)/4] = 32'd0;
        run(1'b0, 64'h0, 1'b0, 1'b0, "R9 pointer retained");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule